// File: doc/BRIEF.md
# Multi-mode return-link line encoder

This block turns a serial NRZ bit stream into the control level of a passive tag's load modulator. A high output switches the modulator on. Three line codes are available, chosen by a two-bit mode input: Manchester, Biphase and Miller. All timing is counted in cycles of the RF-field clock. There is no separate bit clock.

The bit period is a base number of RF cycles shifted left by a rate select. With the defaults this gives 8, 16, 32 or 64 cycles per bit. Each period is split into two equal halves. At the close of every bit the encoder raises a one-cycle request. It takes the next NRZ bit on the clock edge that ends that request cycle.

Mode and rate are captured together with the bit, so a change made partway through a bit waits for the next boundary. After reset the output is low. Biphase and Miller then build their first edges from that low level.

Top module: `retlink_encoder`

## Requirements
- R1: While reset is held and in the cycle after it, `mod_on` is 0 and `bit_req` is 1.
- R2: `bit_req` is high for exactly one cycle per bit. `nrz_in`, `mode` and `rate_sel` are captured on the rising edge that ends that cycle. Output edges from the new bit appear from that edge onward.
- R3: A bit lasts `BASE_PERIOD << rate_sel` cycles (8/16/32/64 by default). `bit_req` stays low in every cycle of a bit except the last. The two halves have equal length.
- R4: With mode 2'b00 (Manchester), a 1 is high for the first half and low for the second. A 0 is low for the first half and high for the second.
- R5: With mode 2'b01 (Biphase), the output inverts at every bit start. A 0 also inverts it at mid-bit, and a 1 does not.
- R6: With mode 2'b10 (Miller), a 1 inverts the output at mid-bit. A 0 that follows a 0 inverts it at bit start. A 0 that follows a 1, or is the first bit after reset, causes no edge.
- R7: In Miller mode at a fixed rate, two successive output edges are never closer than one bit period.
- R8: Changes to `mode` or `rate_sel` made inside a bit leave that bit's waveform and length unchanged.
- R9: The first Biphase or Miller bit after reset starts from a low level. A Biphase 1 is then high for its whole period, and a Miller 0,0 is low for the first bit and high for the second.
- R10: Mode 2'b11 encodes exactly like Manchester.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | RF-field clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Line code: 00 Manchester, 01 Biphase, 10 Miller, 11 Manchester |
| rate_sel | input | RATE_W | Bit period is BASE_PERIOD shifted left by this value |
| nrz_in | input | 1 | Next NRZ bit, captured at the edge ending a `bit_req` cycle |
| bit_req | output | 1 | One-cycle request for the next bit |
| mod_on | output | 1 | Modulator control, high means on |

## Verification
The assertions take it that `BASE_PERIOD` is even and at least 2. Without that, the mid-bit and end-of-bit marks could not be distinct cycles.

The Miller spacing check only covers output edges produced while Miller mode and a single rate were both held, with no change in between. The stimulus keeps rate constant inside each Miller stretch so that this window is exercised. Mode and rate are moved inside a bit only on purpose, to show they are ignored until the next boundary.

// File: rtl/retlink_encoder.sv
module retlink_encoder #(
  parameter int BASE_PERIOD = 8,
  parameter int RATE_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              nrz_in,
  output logic              bit_req,
  output logic              mod_on
);
  localparam int MAX_PERIOD = BASE_PERIOD << ((1 << RATE_W) - 1);
  localparam int CW = $clog2(MAX_PERIOD);

  typedef enum logic [1:0] {
    ENC_MAN = 2'b00,
    ENC_BIP = 2'b01,
    ENC_MIL = 2'b10,
    ENC_ALT = 2'b11
  } enc_e;

  logic              started;
  logic [CW-1:0]     cnt;
  logic              cur_bit;
  logic              last_zero;
  logic              out_q;
  enc_e              mode_q;
  logic [RATE_W-1:0] rate_q;
  logic [CW:0]       period;
  logic              load;
  logic              mid;
  logic              out_load;
  logic              out_mid;

  assign period  = (CW+1)'(BASE_PERIOD) << rate_q;
  assign load    = !started || (cnt == CW'(period - 1'b1));
  assign mid     = started && (cnt == CW'((period >> 1) - 1'b1));
  assign bit_req = load;
  assign mod_on  = out_q;

  always_comb begin
    case (enc_e'(mode))
      ENC_BIP: out_load = ~out_q;
      ENC_MIL: out_load = (!nrz_in && last_zero) ? ~out_q : out_q;
      default: out_load = nrz_in;
    endcase
  end

  always_comb begin
    case (mode_q)
      ENC_BIP: out_mid = cur_bit ? out_q : ~out_q;
      ENC_MIL: out_mid = cur_bit ? ~out_q : out_q;
      default: out_mid = ~cur_bit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started   <= 1'b0;
      cnt       <= '0;
      cur_bit   <= 1'b0;
      last_zero <= 1'b0;
      out_q     <= 1'b0;
      mode_q    <= ENC_MAN;
      rate_q    <= '0;
    end else if (load) begin
      started   <= 1'b1;
      cnt       <= '0;
      cur_bit   <= nrz_in;
      last_zero <= ~nrz_in;
      out_q     <= out_load;
      mode_q    <= enc_e'(mode);
      rate_q    <= rate_sel;
    end else begin
      cnt <= cnt + 1'b1;
      if (mid) out_q <= out_mid;
    end
  end
endmodule

// File: rtl/retlink_encoder_chk.sv
module retlink_encoder_chk #(
  parameter int CW     = 6,
  parameter int RATE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out,
  input logic              req,
  input logic              load,
  input logic              mid,
  input logic [1:0]        mode_q,
  input logic [RATE_W-1:0] rate_q,
  input logic [CW:0]       period
);
  logic              prev_out;
  logic              clean;
  logic [CW+1:0]     run;
  logic [RATE_W-1:0] prev_rate;
  logic              miller;

  assign miller = (mode_q == 2'b10);

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (out == 1'b0 && req == 1'b1));

  p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);

  p_edge_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out != $past(out)) |-> ($past(load) || $past(mid) || !$past(rst_n)));

  p_manch_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mid && mode_q == 2'b00) |=> (out != $past(out)));

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(mode_q) && $stable(rate_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_out  <= 1'b0;
      clean     <= 1'b0;
      run       <= '0;
      prev_rate <= '0;
    end else begin
      prev_out  <= out;
      prev_rate <= rate_q;
      if (out != prev_out) begin
        if (clean && miller && rate_q == prev_rate)
          a_miller_width_r7: assert (run >= (CW+2)'(period));
        run   <= (CW+2)'(1);
        clean <= miller && rate_q == prev_rate;
      end else begin
        if (run != '1) run <= run + 1'b1;
        if (!miller || rate_q != prev_rate) clean <= 1'b0;
      end
    end
  end
endmodule

bind retlink_encoder retlink_encoder_chk #(.CW(CW), .RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out(mod_on), .req(bit_req), .load(load),
  .mid(mid), .mode_q(mode_q), .rate_q(rate_q), .period(period)
);

// File: tb/tb_retlink_encoder.sv
module tb_retlink_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 8;
  localparam int NV = 30;
  localparam logic [4:0] VEC [NV] = '{
    {2'd0,2'd0,1'b1}, {2'd0,2'd0,1'b0}, {2'd0,2'd0,1'b0}, {2'd0,2'd0,1'b1},
    {2'd1,2'd0,1'b1}, {2'd1,2'd0,1'b1}, {2'd1,2'd0,1'b0}, {2'd1,2'd0,1'b0},
    {2'd1,2'd0,1'b1},
    {2'd2,2'd1,1'b1}, {2'd2,2'd1,1'b1}, {2'd2,2'd1,1'b0}, {2'd2,2'd1,1'b0},
    {2'd2,2'd1,1'b0}, {2'd2,2'd1,1'b1}, {2'd2,2'd1,1'b0}, {2'd2,2'd1,1'b1},
    {2'd2,2'd1,1'b0},
    {2'd3,2'd0,1'b1}, {2'd3,2'd0,1'b0}, {2'd3,2'd0,1'b0},
    {2'd0,2'd2,1'b1}, {2'd0,2'd3,1'b0},
    {2'd2,2'd2,1'b0}, {2'd2,2'd2,1'b0}, {2'd2,2'd2,1'b1}, {2'd2,2'd2,1'b1},
    {2'd1,2'd1,1'b0}, {2'd1,2'd1,1'b1}, {2'd2,2'd0,1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [1:0] rate_sel = 2'b00;
  logic       nrz_in = 1'b0;
  logic       bit_req;
  logic       mod_on;

  int checks = 0;
  int fails = 0;
  logic lvl = 1'b0;
  logic lastz = 1'b0;
  logic prev_out = 1'b0;
  logic [1:0] prev_rate = 2'b00;
  bit mil_seg = 1'b0;
  int cyc = 0;
  int last_chg = 0;

  retlink_encoder #(.BASE_PERIOD(BASE), .RATE_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rate_sel(rate_sel),
    .nrz_in(nrz_in), .bit_req(bit_req), .mod_on(mod_on)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %0b expected %0b", tag, cyc, got, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(mod_on, 1'b0, "R1 output low in reset");
    chk(bit_req, 1'b1, "R1 request in reset");
    lvl = 1'b0; lastz = 1'b0; mil_seg = 1'b0; prev_out = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic run_bit(input logic [1:0] m, input logic [1:0] r, input logic d,
                         input bit perturb, input string force_tag);
    int per;
    int half;
    logic f;
    logic s;
    string tag;
    per = BASE << r;
    half = per / 2;
    chk(bit_req, 1'b1, "R2 request at bit end");
    mode = m; rate_sel = r; nrz_in = d;
    case (m)
      2'b01: begin f = ~lvl; s = d ? f : ~f; tag = "R5"; end
      2'b10: begin f = (!d && lastz) ? ~lvl : lvl; s = d ? ~f : f; tag = "R6"; end
      default: begin f = d; s = ~d; tag = (m == 2'b11) ? "R10" : "R4"; end
    endcase
    if (perturb) tag = "R8";
    if (force_tag != "") tag = force_tag;
    if (r != prev_rate) mil_seg = 1'b0;
    @(posedge clk);
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      cyc++;
      if (perturb && i == 1) begin
        mode = (m == 2'b10) ? 2'b00 : 2'b10;
        rate_sel = ~r;
        nrz_in = ~d;
      end
      chk(mod_on, (i < half) ? f : s, tag);
      if (i < per - 1) chk(bit_req, 1'b0, perturb ? "R8 length kept" : "R3 no request mid-bit");
      if (mod_on != prev_out) begin
        if (mil_seg && m == 2'b10) begin
          checks++;
          if (cyc - last_chg < per) begin
            fails++;
            $display("FAIL R7 Miller pulse: got %0d cycles expected >= %0d", cyc - last_chg, per);
          end
        end
        last_chg = cyc;
        mil_seg = (m == 2'b10);
      end
      if (m != 2'b10) mil_seg = 1'b0;
      prev_out = mod_on;
    end
    lvl = s; lastz = ~d; prev_rate = r;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    do_reset();
    for (int k = 0; k < NV; k++)
      run_bit(VEC[k][4:3], VEC[k][2:1], VEC[k][0], 1'b0, "");

    run_bit(2'b00, 2'b00, 1'b1, 1'b1, "");
    run_bit(2'b01, 2'b00, 1'b0, 1'b1, "");
    run_bit(2'b10, 2'b01, 1'b1, 1'b1, "");

    do_reset();
    run_bit(2'b01, 2'b00, 1'b1, 1'b0, "R9 biphase from low");
    do_reset();
    run_bit(2'b10, 2'b00, 1'b0, 1'b0, "R9 miller first zero");
    run_bit(2'b10, 2'b00, 1'b0, 1'b0, "R9 miller second zero");

    chk(bit_req, 1'b1, "R2 request before mid-bit reset");
    mode = 2'b01; rate_sel = 2'b01; nrz_in = 1'b1;
    @(posedge clk);
    repeat (3) @(negedge clk);
    do_reset();
    run_bit(2'b00, 2'b00, 1'b0, 1'b0, "R1 clean restart");
    summary();
  end
endmodule